// File: doc/BRIEF.md
# Multi-Mode 16-bit Counter/Timer

This block is a 16-bit counter with an automatic reload. One counter core serves four modes. In the periodic timer mode it counts prescaler ticks down and reloads. The one-shot mode works the same way but stops after one period. The event mode counts edges on an external input. The measurement mode times how long that input stays active. A terminal count, or the end of a measurement, sets a sticky status flag. That flag drives the interrupt line directly, and software clears it by writing a one. A terminal count can also toggle an external output.

The external input goes through a two-stage synchronizer. Its polarity can then be inverted before the level and edges are derived from it. The output pin has its own polarity inversion. The reload value sits in a register that the block uses at each reload and at each start. Run control is given by two strobes: one sets the run bit and one clears it. The block itself clears the run bit at the end of a one-shot period.

Top module: `ctr16_multimode`

## Requirements
- R1: After reset, the count and the capture are 0, the run bit and the status flag are 0, and the output pin equals the output inversion bit.
- R2: In mode 0 (periodic timer), a start strobe loads the count from the reload register. Each tick while running lowers the count by one. A tick at count 0 loads the reload value and sets the status flag. Ticks have no effect while stopped.
- R3: In mode 1 (one-shot), counting follows R2. The terminal tick also clears the run bit, the count then keeps the reload value, and later ticks leave it unchanged.
- R4: In mode 2 (event), the count moves on active edges of the conditioned input instead of ticks. The rising edge is active when the edge select is 0 and the falling edge when it is 1. An input change shows in the count on the third rising clock edge after it is applied. Underflow behaves as in R2.
- R5: In mode 3 (measurement), a start clears the count. The count rises by one on each tick while the conditioned input is high, and saturates at 0xFFFF. When the conditioned input falls, the count is copied into the capture register, the count returns to 0 and the status flag is set. An input pulse of H clock cycles with the tick held high gives a capture of H.
- R6: The conditioned input is the synchronized pin XOR the input inversion bit. With inversion set, a falling pin edge counts as a rising edge.
- R7: When toggling is enabled, each terminal count inverts an internal toggle bit. The output pin is that bit XOR the output inversion bit.
- R8: A status clear strobe clears the flag. If a set event falls in the same cycle, the flag stays 1. The interrupt output equals the flag.
- R9: A stop strobe clears the run bit and takes priority over a start in the same cycle. When it does, the count is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler clock-enable tick |
| mode_i | input | 2 | 0 timer, 1 one-shot, 2 event, 3 measurement |
| edge_sel_i | input | 1 | Event edge: 0 rising, 1 falling |
| in_inv_i | input | 1 | Invert the external input |
| out_inv_i | input | 1 | Invert the external output |
| tgl_en_i | input | 1 | Toggle the output on terminal count |
| run_set_i | input | 1 | Start strobe (sets run, loads count) |
| run_clr_i | input | 1 | Stop strobe |
| reload_we_i | input | 1 | Reload register write enable |
| reload_wd_i | input | 16 | Reload register write data |
| sts_clr_i | input | 1 | Write-one-to-clear of the status flag |
| ext_in_i | input | 1 | Asynchronous external input pin |
| ext_out_o | output | 1 | External output pin |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Last measured width |
| run_o | output | 1 | Run bit |
| irq_o | output | 1 | Interrupt (status flag) |

## Verification
A terminal count and a software clear of the status flag can fall in the same clock cycle. The bench provokes this in two ways. The directed case brings the count to zero and then raises the tick and the clear strobe together, expecting the flag to stay set and the count to reload. The random timer phase also scatters clear strobes among random ticks. A bench model then judges each cycle's flag, count and output, treating set as winning over clear.

// File: rtl/ctr16_pkg.sv
package ctr16_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_EVENT   = 2'd2,
    MODE_MEASURE = 2'd3
  } ctr_mode_e;
endpackage

// File: rtl/ctr16_insync.sv
module ctr16_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic inv_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              lvl_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    lvl_o  = sync_q[STAGES-1] ^ inv_i;
    rise_o = lvl_o & ~lvl_q;
    fall_o = ~lvl_o & lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      lvl_q  <= lvl_o;
    end
  end

  // R6
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o && $stable(inv_i) && $past(rst_n, STAGES)) |-> ($past(pin_i, STAGES) ^ inv_i));
endmodule

// File: rtl/ctr16_core.sv
module ctr16_core
  import ctr16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctr_mode_e        mode_i,
  input  logic             tick_i,
  input  logic             edge_sel_i,
  input  logic             run_set_i,
  input  logic             run_clr_i,
  input  logic             reload_we_i,
  input  logic [WIDTH-1:0] reload_wd_i,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] capture_o,
  output logic             run_o,
  output logic             term_o,
  output logic             mdone_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] count_q, count_d, cap_q, cap_d, rel_q, rel_d;
  logic             run_q, run_d, step;

  always_comb begin
    step    = (mode_i == MODE_EVENT) ? (edge_sel_i ? fall_i : rise_i) : tick_i;
    run_d   = run_q;
    count_d = count_q;
    cap_d   = cap_q;
    rel_d   = reload_we_i ? reload_wd_i : rel_q;
    term_o  = 1'b0;
    mdone_o = 1'b0;
    if (run_clr_i) begin
      run_d = 1'b0;
    end else if (run_set_i) begin
      run_d   = 1'b1;
      count_d = (mode_i == MODE_MEASURE) ? '0 : rel_q;
    end else if (run_q) begin
      if (mode_i == MODE_MEASURE) begin
        if (fall_i) begin
          cap_d   = count_q;
          count_d = '0;
          mdone_o = 1'b1;
        end else if (lvl_i && tick_i && count_q != CNT_MAX) begin
          count_d = count_q + 1'b1;
        end
      end else if (step) begin
        if (count_q == '0) begin
          count_d = rel_q;
          term_o  = 1'b1;
          if (mode_i == MODE_ONESHOT) run_d = 1'b0;
        end else begin
          count_d = count_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cap_q   <= '0;
      rel_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      cap_q   <= cap_d;
      rel_q   <= rel_d;
      run_q   <= run_d;
    end
  end

  assign count_o   = count_q;
  assign capture_o = cap_q;
  assign run_o     = run_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !run_set_i) |=> $stable(count_q));
  // R3
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_o && mode_i == MODE_ONESHOT) |=> !run_q);
  // R5
  meas_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdone_o |=> (count_q == '0 && cap_q == $past(count_q)));
  // R9
  stop_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr_i |=> (!run_q && $stable(count_q)));
endmodule

// File: rtl/ctr16_flags.sv
module ctr16_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic term_i,
  input  logic mdone_i,
  input  logic sts_clr_i,
  input  logic tgl_en_i,
  input  logic out_inv_i,
  output logic sts_o,
  output logic out_o
);
  logic sts_q, sts_d, tgl_q, tgl_d, set_ev;

  always_comb begin
    set_ev = term_i | mdone_i;
    if (set_ev)         sts_d = 1'b1;
    else if (sts_clr_i) sts_d = 1'b0;
    else                sts_d = sts_q;
    tgl_d = (term_i && tgl_en_i) ? ~tgl_q : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      tgl_q <= tgl_d;
    end
  end

  assign sts_o = sts_q;
  assign out_o = tgl_q ^ out_inv_i;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> sts_q);
  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_i && !set_ev) |=> !sts_q);
  // R7
  tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && tgl_en_i) |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/ctr16_multimode.sv
module ctr16_multimode
  import ctr16_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic             edge_sel_i,
  input  logic             in_inv_i,
  input  logic             out_inv_i,
  input  logic             tgl_en_i,
  input  logic             run_set_i,
  input  logic             run_clr_i,
  input  logic             reload_we_i,
  input  logic [WIDTH-1:0] reload_wd_i,
  input  logic             sts_clr_i,
  input  logic             ext_in_i,
  output logic             ext_out_o,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] capture_o,
  output logic             run_o,
  output logic             irq_o
);
  ctr_mode_e mode;
  logic      lvl, rise, fall, term, mdone;

  assign mode = ctr_mode_e'(mode_i);

  ctr16_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_in_i), .inv_i(in_inv_i),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  ctr16_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tick_i(tick_i),
    .edge_sel_i(edge_sel_i), .run_set_i(run_set_i), .run_clr_i(run_clr_i),
    .reload_we_i(reload_we_i), .reload_wd_i(reload_wd_i),
    .lvl_i(lvl), .rise_i(rise), .fall_i(fall),
    .count_o(count_o), .capture_o(capture_o), .run_o(run_o),
    .term_o(term), .mdone_o(mdone)
  );

  ctr16_flags u_flags (
    .clk(clk), .rst_n(rst_n), .term_i(term), .mdone_i(mdone),
    .sts_clr_i(sts_clr_i), .tgl_en_i(tgl_en_i), .out_inv_i(out_inv_i),
    .sts_o(irq_o), .out_o(ext_out_o)
  );
endmodule

// File: tb/tb_ctr16_multimode.sv
`timescale 1ns/1ps
module tb_ctr16_multimode;
  logic        clk = 1'b0;
  logic        rst_n, tick, edge_sel, in_inv, out_inv, tgl_en;
  logic        run_set, run_clr, reload_we, sts_clr, ext_in;
  logic [1:0]  mode;
  logic [15:0] reload_wd;
  logic        ext_out, run, irq;
  logic [15:0] count, capture;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ctr16_multimode dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .edge_sel_i(edge_sel),
    .in_inv_i(in_inv), .out_inv_i(out_inv), .tgl_en_i(tgl_en), .run_set_i(run_set),
    .run_clr_i(run_clr), .reload_we_i(reload_we), .reload_wd_i(reload_wd),
    .sts_clr_i(sts_clr), .ext_in_i(ext_in), .ext_out_o(ext_out), .count_o(count),
    .capture_o(capture), .run_o(run), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reload(input int v);
    reload_wd = 16'(v); reload_we = 1'b1; cyc(1); reload_we = 1'b0;
  endtask

  task automatic start();
    run_set = 1'b1; cyc(1); run_set = 1'b0;
  endtask

  task automatic stop();
    run_clr = 1'b1; cyc(1); run_clr = 1'b0;
  endtask

  task automatic clr_sts();
    sts_clr = 1'b1; cyc(1); sts_clr = 1'b0;
  endtask

  function automatic int next_cnt(input int c, input int rel);
    return (c == 0) ? rel : c - 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int exp_cnt, exp_rel, exp_out, a;
    bit exp_irq;
    void'($urandom(32'd20177));
    rst_n = 0; tick = 0; mode = 0; edge_sel = 0; in_inv = 0; out_inv = 0; tgl_en = 1;
    run_set = 0; run_clr = 0; reload_we = 0; reload_wd = 0; sts_clr = 0; ext_in = 0;
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    chk("R1", "count", count, 0); chk("R1", "capture", capture, 0);
    chk("R1", "run", run, 0); chk("R1", "irq", irq, 0); chk("R1", "out", ext_out, 0);

    // R2 periodic timer, R7 toggle
    wr_reload(3); start();
    chk("R2", "start load", count, 3); chk("R2", "run", run, 1);
    tick = 1;
    for (int i = 2; i >= 0; i--) begin cyc(1); chk("R2", "down", count, i); end
    chk("R2", "no flag yet", irq, 0);
    cyc(1);
    chk("R2", "reload", count, 3); chk("R2", "flag", irq, 1); chk("R7", "toggle", ext_out, 1);
    tick = 0; cyc(3);
    chk("R2", "no tick hold", count, 3);

    // R8 terminal count and clear in the same cycle
    tick = 1; cyc(3); chk("R8", "at zero", count, 0);
    sts_clr = 1; cyc(1);
    chk("R8", "set wins", irq, 1); chk("R8", "reloaded", count, 3);
    tick = 0; cyc(1); sts_clr = 0;
    chk("R8", "w1c", irq, 0); chk("R7", "toggle back", ext_out, 0);

    // R2 constrained random timer with bench model
    exp_cnt = 3; exp_rel = 3; exp_irq = 0; exp_out = 0;
    for (int i = 0; i < 400; i++) begin
      bit t, w, c, term;
      int nv;
      t = 1'($urandom % 2); w = ($urandom % 16) == 0; c = ($urandom % 8) == 0;
      nv = $urandom % 6;
      tick = t; reload_we = w; reload_wd = 16'(nv); sts_clr = c;
      cyc(1);
      term = t && exp_cnt == 0;
      if (t) exp_cnt = next_cnt(exp_cnt, exp_rel);
      if (w) exp_rel = nv;
      exp_irq = term ? 1'b1 : (c ? 1'b0 : exp_irq);
      if (term) exp_out ^= 1;
      chk("R2", "rand count", count, exp_cnt);
      chk("R8", "rand irq", irq, exp_irq);
      chk("R7", "rand out", ext_out, exp_out);
    end
    tick = 0; reload_we = 0; sts_clr = 0;

    // R3 one-shot
    stop(); clr_sts(); mode = 1; wr_reload(2); start();
    tick = 1; cyc(2);
    chk("R3", "at zero", count, 0); chk("R3", "still run", run, 1);
    cyc(1);
    chk("R3", "stopped", run, 0); chk("R3", "reload", count, 2); chk("R3", "flag", irq, 1);
    cyc(3);
    chk("R3", "held", count, 2);
    tick = 0;

    // R9 stop beats start
    mode = 0; wr_reload(2); start(); wr_reload(7);
    run_set = 1; run_clr = 1; cyc(1); run_set = 0; run_clr = 0;
    chk("R9", "run", run, 0); chk("R9", "no load", count, 2);
    tick = 1; cyc(4); tick = 0;
    chk("R9", "ticks ignored", count, 2);

    // R4 event counting, rising then falling
    clr_sts(); mode = 2; edge_sel = 0; wr_reload(4); start();
    tick = 1;
    chk("R4", "load", count, 4);
    ext_in = 1; cyc(2); chk("R4", "latency before", count, 4);
    cyc(1); chk("R4", "latency at", count, 3);
    ext_in = 0; cyc(4); chk("R4", "falling ignored", count, 3);
    for (int e = 2; e >= 0; e--) begin
      ext_in = 1; cyc(4); ext_in = 0; cyc(4);
      chk("R4", "rise count", count, e);
    end
    ext_in = 1; cyc(4); ext_in = 0; cyc(4);
    chk("R4", "underflow", count, 4); chk("R4", "flag", irq, 1);
    edge_sel = 1;
    ext_in = 1; cyc(4); chk("R4", "rise ignored", count, 4);
    ext_in = 0; cyc(4); chk("R4", "fall count", count, 3);

    // R6 input inversion
    stop(); in_inv = 1; cyc(4); edge_sel = 0; start();
    ext_in = 1; cyc(4); chk("R6", "raw rise ignored", count, 4);
    ext_in = 0; cyc(4); chk("R6", "raw fall counts", count, 3);
    stop(); in_inv = 0; cyc(4);

    // R5 measurement
    mode = 3; clr_sts(); start();
    chk("R5", "start clears", count, 0);
    for (int k = 0; k < 6; k++) begin
      int h;
      h = (k == 0) ? 1 : (k == 1) ? 17 : 2 + ($urandom % 30);
      tick = 1; ext_in = 1; cyc(h); ext_in = 0; cyc(4);
      chk("R5", "capture", capture, h); chk("R5", "count cleared", count, 0);
      chk("R5", "flag", irq, 1);
      clr_sts();
    end
    tick = 0; ext_in = 1; cyc(6); ext_in = 0; cyc(4);
    chk("R5", "no tick capture", capture, 0);

    // R7 output inversion
    a = ext_out; out_inv = 1; #1;
    chk("R7", "out inv", ext_out, 1 - a);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule